// File: doc/BRIEF.md
# Flash Write-Status Reporter

This block is a clocked model of the status a parallel NOR flash presents while an internal program or erase runs. A command front end that has already recognised a complete program or erase sequence gives the block a one-cycle start pulse. With the pulse come the operation class and bit 7 of the word being programmed. From the next cycle the block reports busy for a parameterised number of cycles. It holds the open-drain ready/busy line low, and it answers read strobes with status words in place of array data.

Status words carry two flags. Bit 7 is a data-complement flag: it reads as the inverse of the programmed bit, or as 0 during an erase. Bit 6 inverts on every busy read. When the busy count runs out the block emits a one-cycle done pulse and then enters a bus-recovery window. In that window reads still return the finished status form. After the window, reads return the array word that the surrounding logic presents. A hardware reset input aborts any running operation at once.

Top module: `nor_wstat_rpt`

## Requirements
- R1: After system reset the read register holds 0. In the ready state, a read (rd_i high with ce_n_i low and hrst_n_i high) loads mem_data_i into rdata_o at the next clock edge.
- R2: While a program (op_i = 2'b00) is busy, a read returns bit 7 equal to the inverse of the pgm_d7_i value captured at start. All bits other than 7 and 6 read as 0.
- R3: While an erase (op_i other than 2'b00) is busy, bit 7 reads 0. In the recovery window, bit 7 reads 1 after an erase and reads the captured pgm_d7_i after a program.
- R4: Bit 6 is a toggle flag that starts at 0 after system reset. Each busy read returns the flag and then inverts it. Reads in any other state leave it unchanged, so two reads in recovery return the same bit 6.
- R5: busy_pull_o is 1 only while an operation is busy, chip enable is low (ce_n_i = 0) and hrst_n_i is high. It is 0 out of reset.
- R6: A start pulse accepted in the ready state begins busy at the next edge. Busy lasts PROG_CYC cycles for op 2'b00, SECT_CYC for op 2'b01, and CHIP_CYC for op 2'b10 or 2'b11.
- R7: hrst_n_i low returns the block to the ready state at the next edge with no done pulse. While hrst_n_i is low, reads and start pulses are ignored.
- R8: done_o is high for exactly one cycle, the last busy cycle of an operation that is not aborted.
- R9: A recovery window of REC_CYC cycles follows busy. Reads in it return the status form with all bits other than 7 and 6 at 0. After it, reads return mem_data_i.
- R10: Start pulses during busy or recovery are ignored and do not change the duration or the operation class. A read with ce_n_i high leaves rdata_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hrst_n_i | input | 1 | Active-low hardware reset pin, sampled synchronously |
| start_i | input | 1 | One-cycle pulse: a complete program/erase sequence was decoded |
| op_i | input | 2 | Operation class: 00 program, 01 sector/block erase, 1x chip erase |
| pgm_d7_i | input | 1 | Bit 7 of the word being programmed |
| ce_n_i | input | 1 | Active-low chip enable |
| rd_i | input | 1 | Read strobe, one read per high cycle |
| mem_data_i | input | DW | Array word at the read address |
| rdata_o | output | DW | Registered read data |
| busy_pull_o | output | 1 | 1 = ready/busy line pulled low; 0 = released |
| done_o | output | 1 | One-cycle pulse in the last busy cycle |

## Verification
The assertions rely on a start pulse lasting exactly one cycle, and on the inputs changing only between clock edges. The bench drives every input on the falling edge and raises start only for a single cycle. The bench issues starts both in the ready state and deliberately while an operation is busy. It also asserts the hardware reset mid-operation and combines it with reads and starts. This exercises the abort and the ignore paths without relying on anything the block does not define.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_BUSY  = 2'd1,
    ST_RECOV = 2'd2
  } fsr_state_e;

  localparam logic [1:0] OP_PROG = 2'b00;
  localparam logic [1:0] OP_SECT = 2'b01;
  localparam logic [1:0] OP_CHIP = 2'b10;

endpackage

// File: rtl/fsr_timer.sv
module fsr_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          run_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i))); // R6

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && zero_o) |=> zero_o); // R6

endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip_i,
  output logic tog_o
);

  logic tog_q, tog_d;

  always_comb begin
    tog_d = tog_q;
    if (flip_i) begin
      tog_d = ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
    end
  end

  assign tog_o = tog_q;

  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flip_i |=> $stable(tog_o)); // R4

  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    flip_i |=> (tog_o != $past(tog_o))); // R4

endmodule

// File: rtl/fsr_rdfmt.sv
module fsr_rdfmt
  import fsr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture_i,
  input  fsr_state_e    state_i,
  input  logic          is_prog_i,
  input  logic          tgt_b7_i,
  input  logic          tog_i,
  input  logic [DW-1:0] mem_data_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] word_d;
  logic [DW-1:0] rdata_q;

  always_comb begin
    word_d = '0;
    unique case (state_i)
      ST_BUSY: begin
        word_d[7] = is_prog_i ? ~tgt_b7_i : 1'b0;
        word_d[6] = tog_i;
      end
      ST_RECOV: begin
        word_d[7] = is_prog_i ? tgt_b7_i : 1'b1;
        word_d[6] = tog_i;
      end
      default: word_d = mem_data_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture_i) begin
      rdata_q <= word_d;
    end
  end

  assign rdata_o = rdata_q;

  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && state_i == ST_BUSY && !is_prog_i) |=> (rdata_o[7] == 1'b0)); // R3

  AST_NO_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(rdata_o)); // R10

endmodule

// File: rtl/nor_wstat_rpt.sv
module nor_wstat_rpt
  import fsr_pkg::*;
#(
  parameter int DW       = 16,
  parameter int PROG_CYC = 12,
  parameter int SECT_CYC = 30,
  parameter int CHIP_CYC = 50,
  parameter int REC_CYC  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hrst_n_i,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic          pgm_d7_i,
  input  logic          ce_n_i,
  input  logic          rd_i,
  input  logic [DW-1:0] mem_data_i,
  output logic [DW-1:0] rdata_o,
  output logic          busy_pull_o,
  output logic          done_o
);

  localparam int MAX_A   = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_B   = (CHIP_CYC > REC_CYC) ? CHIP_CYC : REC_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW      = $clog2(MAX_CYC + 1);

  fsr_state_e    st_q, st_d;
  logic [1:0]    op_q;
  logic          b7_q;
  logic          lat_en;
  logic          tmr_load, tmr_run, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic [CW-1:0] op_len;
  logic          capture, flip, tog;

  always_comb begin
    unique case (op_i)
      OP_PROG: op_len = CW'(PROG_CYC - 1);
      OP_SECT: op_len = CW'(SECT_CYC - 1);
      default: op_len = CW'(CHIP_CYC - 1);
    endcase
  end

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    lat_en   = 1'b0;
    if (!hrst_n_i) begin
      st_d = ST_READY;
    end else begin
      unique case (st_q)
        ST_READY: begin
          if (start_i) begin
            st_d     = ST_BUSY;
            tmr_load = 1'b1;
            tmr_val  = op_len;
            lat_en   = 1'b1;
          end
        end
        ST_BUSY: begin
          if (tmr_zero) begin
            st_d     = ST_RECOV;
            tmr_load = 1'b1;
            tmr_val  = CW'(REC_CYC - 1);
          end
        end
        ST_RECOV: begin
          if (tmr_zero) begin
            st_d = ST_READY;
          end
        end
        default: st_d = ST_READY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_READY;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_PROG;
      b7_q <= 1'b0;
    end else if (lat_en) begin
      op_q <= op_i;
      b7_q <= pgm_d7_i;
    end
  end

  assign tmr_run = (st_q != ST_READY) && hrst_n_i;
  assign capture = rd_i && !ce_n_i && hrst_n_i;
  assign flip    = capture && (st_q == ST_BUSY);

  fsr_timer #(.CW(CW)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .run_i      (tmr_run),
    .zero_o     (tmr_zero)
  );

  fsr_toggle toggle_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .flip_i (flip),
    .tog_o  (tog)
  );

  fsr_rdfmt #(.DW(DW)) rdfmt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_i  (capture),
    .state_i    (st_q),
    .is_prog_i  (op_q == OP_PROG),
    .tgt_b7_i   (b7_q),
    .tog_i      (tog),
    .mem_data_i (mem_data_i),
    .rdata_o    (rdata_o)
  );

  assign busy_pull_o = (st_q == ST_BUSY) && !ce_n_i && hrst_n_i;
  assign done_o      = (st_q == ST_BUSY) && tmr_zero && hrst_n_i;

  AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READY && start_i && hrst_n_i) |=> (st_q == ST_BUSY)); // R6

  AST_HRST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !hrst_n_i |=> (st_q == ST_READY)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_DONE_TO_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (st_q == ST_RECOV)); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_READY && start_i) |=> ($stable(op_q) && $stable(b7_q))); // R10

  AST_PULL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RECOV) |-> !busy_pull_o); // R5

endmodule

// File: tb/nor_wstat_rpt_tb_top.sv
module nor_wstat_rpt_tb_top;

  localparam int DW       = 16;
  localparam int PROG_CYC = 12;
  localparam int SECT_CYC = 30;
  localparam int CHIP_CYC = 50;
  localparam int REC_CYC  = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hrst_n_i;
  logic          start_i;
  logic [1:0]    op_i;
  logic          pgm_d7_i;
  logic          ce_n_i;
  logic          rd_i;
  logic [DW-1:0] mem_data_i;
  logic [DW-1:0] rdata_o;
  logic          busy_pull_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;
  bit model_on = 1'b0;

  always #10 clk = ~clk;

  nor_wstat_rpt #(
    .DW(DW), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
    .CHIP_CYC(CHIP_CYC), .REC_CYC(REC_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .hrst_n_i(hrst_n_i), .start_i(start_i),
    .op_i(op_i), .pgm_d7_i(pgm_d7_i), .ce_n_i(ce_n_i), .rd_i(rd_i),
    .mem_data_i(mem_data_i), .rdata_o(rdata_o),
    .busy_pull_o(busy_pull_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model: 0 ready, 1 busy, 2 recovery
  int            m_st;
  int            m_cnt;
  bit            m_tog;
  int            m_op;
  bit            m_b7;
  logic [DW-1:0] m_rdata;

  function automatic int op_len(input int op);
    if (op == 0) return PROG_CYC;
    if (op == 1) return SECT_CYC;
    return CHIP_CYC;
  endfunction

  function automatic logic [DW-1:0] m_word(input int st);
    logic [DW-1:0] w;
    w = '0;
    if (st == 1) begin
      w[7] = (m_op == 0) ? ~m_b7 : 1'b0;
      w[6] = m_tog;
    end else if (st == 2) begin
      w[7] = (m_op == 0) ? m_b7 : 1'b1;
      w[6] = m_tog;
    end else begin
      w = mem_data_i;
    end
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_tog = 1'b0; m_op = 0; m_b7 = 1'b0; m_rdata = '0;
    end else begin
      int pre;
      pre = m_st;
      if (rd_i && !ce_n_i && hrst_n_i) begin
        m_rdata = m_word(pre);
        if (pre == 1) m_tog = ~m_tog;
      end
      if (!hrst_n_i) begin
        m_st = 0;
      end else if (pre == 0) begin
        if (start_i) begin
          m_op = int'(op_i); m_b7 = pgm_d7_i; m_cnt = op_len(int'(op_i)); m_st = 1;
        end
      end else if (pre == 1) begin
        m_cnt--;
        if (m_cnt == 0) begin m_st = 2; m_cnt = REC_CYC; end
      end else begin
        m_cnt--;
        if (m_cnt == 0) m_st = 0;
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (model_on && rst_n) begin
      chk("R1 rdata vs model", 32'(rdata_o), 32'(m_rdata));
      chk("R5 busy_pull vs model", 32'(busy_pull_o),
          32'((m_st == 1) && !ce_n_i && hrst_n_i));
      chk("R8 done vs model", 32'(done_o),
          32'((m_st == 1) && (m_cnt == 1) && hrst_n_i));
    end
  end

  task automatic start_pulse(input logic [1:0] op, input logic b7);
    start_i = 1'b1; op_i = op; pgm_d7_i = b7;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] op, input logic b7, output int bc, output int dn);
    int guard;
    start_pulse(op, b7);
    bc = 0; dn = 0; guard = 0;
    while (busy_pull_o && guard < 1000) begin
      bc++;
      if (done_o) dn++;
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic read1();
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic wait_ready();
    int guard;
    guard = 0;
    while (busy_pull_o && guard < 1000) begin guard++; @(negedge clk); end
    repeat (REC_CYC + 2) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bc, dn;
    logic [DW-1:0] r1, r2;
    rst_n = 1'b0; hrst_n_i = 1'b1; start_i = 1'b0; op_i = 2'b00; pgm_d7_i = 1'b0;
    ce_n_i = 1'b0; rd_i = 1'b0; mem_data_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", 32'(rdata_o), 32'h0);
    chk("R5 reset busy_pull", 32'(busy_pull_o), 32'h0);
    chk("R8 reset done", 32'(done_o), 32'h0);
    rst_n = 1'b1; model_on = 1'b1;
    @(negedge clk);

    mem_data_i = 16'hA5C3;
    read1();
    chk("R1 ready read", 32'(rdata_o), 32'hA5C3);

    run_op(2'b00, 1'b1, bc, dn);
    chk("R6 program duration", bc, PROG_CYC);
    chk("R8 program done count", dn, 1);
    mem_data_i = 16'hFFFF;
    read1();
    chk("R3 program recovery bit7 true", 32'(rdata_o[7]), 32'h1);
    chk("R9 recovery other bits zero", 32'(rdata_o & 16'hFF3F), 32'h0);
    repeat (REC_CYC + 2) @(negedge clk);
    mem_data_i = 16'h1234;
    read1();
    chk("R9 array data after recovery", 32'(rdata_o), 32'h1234);

    start_pulse(2'b00, 1'b1);
    rd_i = 1'b1;
    @(negedge clk);
    r1 = rdata_o;
    @(negedge clk);
    rd_i = 1'b0;
    r2 = rdata_o;
    chk("R2 program busy bit7 complement", 32'(r1[7]), 32'h0);
    chk("R2 program busy other bits", 32'(r1 & 16'hFF3F), 32'h0);
    chk("R4 bit6 flips between busy reads", 32'((r1 ^ r2) & 16'h0040), 32'h40);
    ce_n_i = 1'b1;
    #1;
    chk("R5 pull released with ce high", 32'(busy_pull_o), 32'h0);
    read1();
    chk("R10 read ignored with ce high", 32'(rdata_o), 32'(r2));
    ce_n_i = 1'b0;
    #1;
    while (busy_pull_o) @(negedge clk);
    rd_i = 1'b1;
    @(negedge clk);
    r1 = rdata_o;
    @(negedge clk);
    rd_i = 1'b0;
    r2 = rdata_o;
    chk("R4 bit6 steady in recovery", 32'((r1 ^ r2) & 16'h0040), 32'h0);
    repeat (REC_CYC + 2) @(negedge clk);

    start_pulse(2'b00, 1'b0);
    bc = 0;
    for (int k = 0; k < 1000 && busy_pull_o; k++) begin
      bc++;
      start_i = (k == 3);
      op_i = 2'b10;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R10 start during busy ignored", bc, PROG_CYC);
    repeat (REC_CYC + 2) @(negedge clk);

    start_pulse(2'b01, 1'b1);
    read1();
    chk("R3 erase busy bit7 zero", 32'(rdata_o[7]), 32'h0);
    while (busy_pull_o) @(negedge clk);
    read1();
    chk("R3 erase recovery bit7 one", 32'(rdata_o[7]), 32'h1);
    repeat (REC_CYC + 2) @(negedge clk);

    run_op(2'b01, 1'b0, bc, dn);
    chk("R6 sector erase duration", bc, SECT_CYC);
    repeat (REC_CYC + 2) @(negedge clk);
    run_op(2'b10, 1'b0, bc, dn);
    chk("R6 chip erase duration op10", bc, CHIP_CYC);
    chk("R8 chip erase done count", dn, 1);
    repeat (REC_CYC + 2) @(negedge clk);
    run_op(2'b11, 1'b0, bc, dn);
    chk("R6 chip erase duration op11", bc, CHIP_CYC);
    repeat (REC_CYC + 2) @(negedge clk);

    start_pulse(2'b00, 1'b1);
    repeat (3) @(negedge clk);
    r1 = rdata_o;
    hrst_n_i = 1'b0; rd_i = 1'b1; start_i = 1'b1;
    #1;
    chk("R7 pull released in hw reset", 32'(busy_pull_o), 32'h0);
    @(negedge clk);
    chk("R7 read ignored in hw reset", 32'(rdata_o), 32'(r1));
    rd_i = 1'b0; start_i = 1'b0; hrst_n_i = 1'b1;
    @(negedge clk);
    chk("R7 aborted and start ignored", 32'(busy_pull_o), 32'h0);
    chk("R7 no done after abort", 32'(done_o), 32'h0);
    mem_data_i = 16'h0BEE;
    read1();
    chk("R7 ready read after abort", 32'(rdata_o), 32'h0BEE);
    wait_ready();

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule